// File: doc/BRIEF.md
# Serial Flash Status-Write Command Handler

This block is the slave-side command logic that a serial flash uses for its status-register write. It watches the chip-select, serial clock and serial data lines of an SPI mode-0 bus, and it also watches a write-protect pin. It keeps three pieces of state: a write-enable latch, a sector-protection lock bit, and a one-cycle request that asks the protection logic next to it to protect or unprotect every sector. All of the SPI pins and the protect pin are resynchronised into the system clock. The block therefore only needs the system clock to run several times faster than the serial clock.

A transaction has effect only when chip-select rises. At that point the block looks at the opcode and at how many bits arrived. It checks that the count ended on a byte boundary. It also checks the latch, the present lock value and the protect pin. From these it decides whether to change the lock bit and whether to raise a global request. A short write-enable command sets the latch, and that latch arms the next status write.

Top module: `sfl_status_cmd`

## Requirements
- R1: After reset the lock bit, the write-enable latch and both global request outputs are 0.
- R2: A frame holding exactly 8 bits that carry the write-enable opcode 0x06 sets the write-enable latch when chip-select rises. A frame with the same opcode but any other bit count leaves the latch unchanged.
- R3: Serial data is sampled on rising serial clock, MSB first. In a status-write frame (opcode 0x01), bit 7 of the first data byte becomes the new lock bit. Bits 6, 1 and 0 of that byte are don't-care. The lock bit never changes while chip-select is low.
- R4: A status write that arrives while the write-enable latch is 0 leaves the lock bit unchanged and raises no global request.
- R5: Only the first data byte is used. Bytes that follow it in the same frame have no effect.
- R6: A status-write frame aborts if chip-select rises before 16 bits have arrived, or after a bit count that is not a multiple of 8. On abort the lock bit is unchanged and no global request is raised.
- R7: While the write-protect pin is low, a status write may set the lock bit but not clear it. A write that tries to clear it is ignored as a whole: the lock is unchanged and no request is raised.
- R8: An accepted status write with data bits 5..2 = 1111 raises the global-protect output for exactly one cycle.
- R9: An accepted status write with data bits 5..2 = 0000 raises the global-unprotect output for exactly one cycle, but only if the lock bit was 0 before the write. The two requests are never high together.
- R10: Every status-write frame of at least 8 bits clears the write-enable latch when chip-select rises. This holds whether the write was accepted, aborted or ignored.
- R11: Bit and byte framing restart each time chip-select goes high. An aborted frame does not disturb the frame that follows it.
- R12: The lock bit and the latch show the outcome of a frame no later than SYNC_STAGES+2 system clock cycles after chip-select rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_cs_n | input | 1 | Chip-select, active low |
| spi_sck | input | 1 | Serial clock, mode 0 |
| spi_mosi | input | 1 | Serial data into the block |
| wp_pin | input | 1 | Write-protect pin (active low by default) |
| lock_o | output | 1 | Sector-protection lock bit |
| wel_o | output | 1 | Write-enable latch |
| gprot_o | output | 1 | One-cycle global-protect request |
| gunprot_o | output | 1 | One-cycle global-unprotect request |

## Verification
Suppose the captured opcode, data byte or bit count goes wrong inside the block. This shows at the ports one commit latency after chip-select rises: the lock bit takes the wrong value, the latch stays set, or a request pulse is missing or extra. A bit counter that fails to restart shows up on the frame after an abort, because that valid frame then mis-decodes. A pulse that lasts longer than one cycle, or that shows up without the matching accepted write, is caught by the pulse scoreboard on the cycle it appears. The bench also checks the lock and latch values just before chip-select rises, so an early update is caught as well.

// File: rtl/sfl_pkg.sv
package sfl_pkg;

   // Field positions in the status-write data byte (decoded by protection logic)
   localparam int LOCK_BIT   = 7;
   localparam int GCODE_MSB  = 5;
   localparam int GCODE_LSB  = 2;
   localparam int GCODE_W    = GCODE_MSB - GCODE_LSB + 1;

   // Saturating byte count: 0, 1, 2, 3 (=3 or more)
   localparam int NBYTE_W    = 2;

   typedef struct packed {
      logic [7:0]         opcode;   // first byte of the frame
      logic [7:0]         data;     // second byte of the frame
      logic [NBYTE_W-1:0] nbyte;    // completed bytes, saturating
      logic               aligned;  // bit count is a multiple of eight
   } sfl_frame_t;

endpackage

// File: rtl/sfl_sync.sv
module sfl_sync #(
   parameter int             W       = 4,
   parameter int             STAGES  = 2,
   parameter logic [W-1:0]   RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   if (STAGES < 2) begin : g_bad_stages
      $error("sfl_sync: STAGES must be at least 2");
   end
   if (W < 1) begin : g_bad_width
      $error("sfl_sync: W must be at least 1");
   end

   logic [W-1:0] stg [STAGES];

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[0] <= RST_VAL;
            else        stg[0] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[i] <= RST_VAL;
            else        stg[i] <= stg[i-1];
         end
      end
   end

   assign q = stg[STAGES-1];

endmodule

// File: rtl/sfl_shifter.sv
module sfl_shifter
   import sfl_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       cs_hi,
   input  logic       sck,
   input  logic       mosi,
   output sfl_frame_t frame
);

   localparam logic [NBYTE_W-1:0] NBYTE_MAX = '1;

   logic       sck_q;
   logic       sck_rise;
   logic [2:0] bit_idx;
   logic [7:0] sh;
   logic [7:0] sh_nxt;
   logic [7:0] opc_q;
   logic [7:0] dat_q;
   logic [NBYTE_W-1:0] nbyte_q;

   assign sck_rise = sck && !sck_q && !cs_hi;
   assign sh_nxt   = {sh[6:0], mosi};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sck_q <= 1'b0;
      else        sck_q <= sck;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bit_idx <= '0;
         nbyte_q <= '0;
         sh      <= '0;
         opc_q   <= '0;
         dat_q   <= '0;
      end else if (cs_hi) begin
         bit_idx <= '0;
         nbyte_q <= '0;
      end else if (sck_rise) begin
         sh      <= sh_nxt;
         bit_idx <= bit_idx + 3'd1;
         if (bit_idx == 3'd7) begin
            if (nbyte_q == '0)                  opc_q <= sh_nxt;
            if (nbyte_q == NBYTE_W'(1))         dat_q <= sh_nxt;
            if (nbyte_q != NBYTE_MAX)           nbyte_q <= nbyte_q + NBYTE_W'(1);
         end
      end
   end

   assign frame.opcode  = opc_q;
   assign frame.data    = dat_q;
   assign frame.nbyte   = nbyte_q;
   assign frame.aligned = (bit_idx == 3'd0);

   // framing restarts whenever chip-select is high
   p_frame_restart_r11: assert property (@(posedge clk) disable iff (!rst_n)
      cs_hi |=> (bit_idx == 3'd0 && nbyte_q == '0));

endmodule

// File: rtl/sfl_commit.sv
module sfl_commit
   import sfl_pkg::*;
#(
   parameter logic [7:0] OPC_WREN = 8'h06,
   parameter logic [7:0] OPC_WRSR = 8'h01
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       commit,
   input  sfl_frame_t frame,
   input  logic       wp_on,
   output logic       lock,
   output logic       wel,
   output logic       gprot,
   output logic       gunprot
);

   if (OPC_WREN == OPC_WRSR) begin : g_bad_opc
      $error("sfl_commit: opcodes must differ");
   end

   logic               is_wren;
   logic               is_wrsr;
   logic               full_frame;
   logic               wp_block;
   logic               accept;
   logic               new_lock;
   logic [GCODE_W-1:0] gcode;
   logic               unused_dc;

   assign new_lock   = frame.data[LOCK_BIT];
   assign gcode      = frame.data[GCODE_MSB:GCODE_LSB];
   assign unused_dc  = ^{frame.data[6], frame.data[1:0]};

   assign is_wren    = commit && frame.opcode == OPC_WREN
                       && frame.nbyte == NBYTE_W'(1) && frame.aligned;
   assign is_wrsr    = commit && frame.opcode == OPC_WRSR && frame.nbyte != '0;
   assign full_frame = frame.nbyte >= NBYTE_W'(2) && frame.aligned;
   assign wp_block   = wp_on && !new_lock;
   assign accept     = is_wrsr && full_frame && wel && !wp_block;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lock    <= 1'b0;
         wel     <= 1'b0;
         gprot   <= 1'b0;
         gunprot <= 1'b0;
      end else begin
         gprot   <= accept && (gcode == '1);
         gunprot <= accept && (gcode == '0) && !lock;
         if (accept)       lock <= new_lock;
         if (is_wrsr)      wel  <= 1'b0;
         else if (is_wren) wel  <= 1'b1;
      end
   end

   p_lock_only_at_commit_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !commit |=> $stable(lock));

   p_wp_keeps_lock_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (commit && wp_on && lock) |=> lock);

   p_gprot_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
      gprot |=> !gprot);

   p_req_exclusive_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({gprot, gunprot}));

   p_unprot_prior_r9: assert property (@(posedge clk) disable iff (!rst_n)
      gunprot |-> !$past(lock));

   p_wel_drop_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (commit && frame.opcode == OPC_WRSR && frame.nbyte != '0) |=> !wel);

endmodule

// File: rtl/sfl_status_cmd.sv
module sfl_status_cmd
   import sfl_pkg::*;
#(
   parameter int         SYNC_STAGES   = 2,
   parameter bit         WP_ACTIVE_LOW = 1'b1,
   parameter logic [7:0] OPC_WREN      = 8'h06,
   parameter logic [7:0] OPC_WRSR      = 8'h01
) (
   input  logic clk,
   input  logic rst_n,
   input  logic spi_cs_n,
   input  logic spi_sck,
   input  logic spi_mosi,
   input  logic wp_pin,
   output logic lock_o,
   output logic wel_o,
   output logic gprot_o,
   output logic gunprot_o
);

   localparam int         NSIG    = 4;
   localparam logic [3:0] SYN_RST = {1'b1, 1'b0, 1'b0, WP_ACTIVE_LOW};

   logic [NSIG-1:0] raw;
   logic [NSIG-1:0] syn;
   logic            cs_s, sck_s, mosi_s, wp_s;
   logic            cs_q;
   logic            cs_rise;
   logic            wp_on;
   sfl_frame_t      frame;

   assign raw = {spi_cs_n, spi_sck, spi_mosi, wp_pin};
   assign {cs_s, sck_s, mosi_s, wp_s} = syn;

   sfl_sync #(.W(NSIG), .STAGES(SYNC_STAGES), .RST_VAL(SYN_RST)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (raw),
      .q     (syn)
   );

   if (WP_ACTIVE_LOW) begin : g_wp_low
      assign wp_on = !wp_s;
   end else begin : g_wp_high
      assign wp_on = wp_s;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cs_q <= 1'b1;
      else        cs_q <= cs_s;
   end
   assign cs_rise = cs_s && !cs_q;

   sfl_shifter u_shift (
      .clk   (clk),
      .rst_n (rst_n),
      .cs_hi (cs_s),
      .sck   (sck_s),
      .mosi  (mosi_s),
      .frame (frame)
   );

   sfl_commit #(.OPC_WREN(OPC_WREN), .OPC_WRSR(OPC_WRSR)) u_commit (
      .clk     (clk),
      .rst_n   (rst_n),
      .commit  (cs_rise),
      .frame   (frame),
      .wp_on   (wp_on),
      .lock    (lock_o),
      .wel     (wel_o),
      .gprot   (gprot_o),
      .gunprot (gunprot_o)
   );

   p_wel_set_needs_commit_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!wel_o && !cs_rise) |=> !wel_o);

endmodule

// File: tb/sfl_status_cmd_tb.sv
module sfl_status_cmd_tb;

   localparam int HP = 3;   // serial clock half period in system clocks

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cs_n = 1'b1, sck = 1'b0, mosi = 1'b0, wp = 1'b1;
   logic lock, wel, gp, gu;

   int total = 0;
   int bad   = 0;
   int exp_q[$];          // 1 = protect, 2 = unprotect
   bit m_lock = 1'b0, m_wel = 1'b0;

   always #10 clk = ~clk;   // 50 MHz

   sfl_status_cmd u_dut (
      .clk(clk), .rst_n(rst_n), .spi_cs_n(cs_n), .spi_sck(sck),
      .spi_mosi(mosi), .wp_pin(wp), .lock_o(lock), .wel_o(wel),
      .gprot_o(gp), .gunprot_o(gu)
   );

   task automatic chk(input string req, input logic act, input logic exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: got %0b expected %0b", req, act, exp);
      end
   endtask

   // scoreboard monitor: every request pulse must match a queued expectation
   always @(negedge clk) begin
      if (rst_n && (gp || gu)) begin
         total++;
         if (gp && gu) begin
            bad++;
            $display("FAIL R9: both requests high, got 11 expected one-hot");
         end else if (exp_q.size() == 0) begin
            bad++;
            $display("FAIL R8/R9: unexpected pulse got %0d expected none", gp ? 1 : 2);
         end else begin
            int e;
            e = exp_q.pop_front();
            if (e != (gp ? 1 : 2)) begin
               bad++;
               $display("FAIL R8/R9: pulse got %0d expected %0d", gp ? 1 : 2, e);
            end
         end
      end
   end

   // driver: sends nbits of vec MSB first, models the expected outcome
   task automatic frame(input logic [31:0] vec, input int nbits, input string req);
      logic [7:0] op, d;
      op = vec[31:24];
      d  = vec[23:16];
      @(negedge clk); cs_n = 1'b0;
      repeat (HP) @(negedge clk);
      for (int i = 0; i < nbits; i++) begin
         mosi = vec[31-i];
         repeat (HP) @(negedge clk); sck = 1'b1;
         repeat (HP) @(negedge clk); sck = 1'b0;
      end
      repeat (6) @(negedge clk);
      chk({req, " R3 hold before CS rise (lock)"}, lock, m_lock);
      chk({req, " R3 hold before CS rise (wel)"}, wel, m_wel);
      // expected result per requirements
      if (nbits == 8 && op == 8'h06) m_wel = 1'b1;
      if (nbits >= 8 && op == 8'h01) begin
         if (m_wel && nbits >= 16 && nbits % 8 == 0 && !(!wp && !d[7])) begin
            if (d[5:2] == 4'hF) exp_q.push_back(1);
            if (d[5:2] == 4'h0 && !m_lock) exp_q.push_back(2);
            m_lock = d[7];
         end
         m_wel = 1'b0;
      end
      cs_n = 1'b1;
      repeat (4) @(negedge clk);   // SYNC_STAGES+2 edges
      chk({req, " R12 lock"}, lock, m_lock);
      chk({req, " R12 wel"},  wel,  m_wel);
      repeat (4) @(negedge clk);
      total++;
      if (exp_q.size() != 0) begin
         bad++;
         $display("FAIL %s: missing pulse got none expected %0d", req, exp_q[0]);
         exp_q.delete();
      end
   endtask

   task automatic wren(input string req);
      frame({8'h06, 24'h0}, 8, req);
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      bad++; total++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      chk("R1 lock reset", lock, 1'b0);
      chk("R1 wel reset",  wel,  1'b0);
      chk("R1 gprot reset", gp,  1'b0);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);

      frame({8'h01, 8'h80, 16'h0}, 16, "R4 no latch");
      frame({8'h06, 24'h0}, 7, "R2 short wren");
      frame({8'h06, 24'h0}, 16, "R2 long wren");
      wren("R2 wren");
      frame({8'h01, 8'h80, 16'h0}, 16, "R3 R9 set lock unprot");
      wren("R2");
      frame({8'h01, 8'h00, 16'h0}, 16, "R9 clear no unprot");
      wren("R2");
      frame({8'h01, 8'h3C, 16'h0}, 16, "R8 protect");
      wren("R2");
      frame({8'h01, 8'hC3, 8'h00, 8'hFF}, 32, "R5 extra bytes");
      wp = 1'b0;
      wren("R2");
      frame({8'h01, 8'h00, 16'h0}, 16, "R7 wp blocks clear");
      wp = 1'b1;
      wren("R2");
      frame({8'h01, 8'h00, 16'h0}, 16, "R7 clear wp off");
      wp = 1'b0;
      wren("R2");
      frame({8'h01, 8'hBC, 16'h0}, 16, "R7 R8 set under wp");
      wp = 1'b1;
      wren("R2");
      frame({8'h01, 8'h3C, 16'h0}, 12, "R6 R10 abort 12");
      wren("R2");
      frame({8'h01, 24'h0}, 8, "R6 R10 abort 8");
      wren("R2");
      frame({8'h01, 8'h3C, 16'h0}, 20, "R6 abort 20");
      wren("R11 after abort");
      frame({8'h01, 8'h00, 16'h0}, 16, "R11 valid after abort");
      wren("R2");
      frame({8'h01, 8'h7C, 16'h0}, 16, "R3 R8 dont-care bit6");

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule